// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer of a per-core interrupt controller. Software sets it up through a small register port with four registers: a timer entry word, an initial count, a live current count and a divide setting. The entry word holds the interrupt vector, a mask bit and a periodic-mode bit. The timer decrements once per divided tick. The tick rate is the core clock divided by a power of two, and the power comes from a three-bit code spread over non-adjacent bits.

In one-shot mode the count runs down to zero and stays there, and the timer reports a single expiry. In periodic mode the count reloads from the initial value after it reaches zero, so one period lasts one tick more than the programmed count. On each expiry with the mask bit clear, the block drives a one-cycle request that carries the 8-bit vector. This request is edge-style and is meant for the controller's pending-request logic.

Top module: `lapic_timer`

## Requirements
- R1: After reset the entry word reads 0x0001_0000 (masked, one-shot, vector 0). The initial count, current count and divide setting all read 0, and no request is driven.
- R2: A write to the divide setting (address 3) keeps only bits 3, 1 and 0. Every other bit reads back as 0.
- R3: The tick period is 2^e clock cycles, where e = ({bit3, bit1, bit0} + 1) mod 8 of the divide setting. Code 0xB gives e = 0 (every cycle) and code 0x0 gives e = 1.
- R4: A write to the initial count (address 1) loads the current count (address 2) with the written value and restarts the divider phase. The initial count reads back the last value written.
- R5: In one-shot mode (entry bit 17 = 0) with initial count N > 0, the current count falls by one per tick and holds at 0. Exactly one expiry occurs, (N+1)·2^e cycles after the load.
- R6: In periodic mode (entry bit 17 = 1) the count reloads N after the tick at which it reads 0. Expiries repeat every (N+1)·2^e cycles.
- R7: With the mask bit (entry bit 16) set, an expiry produces no request, and counting continues.
- R8: A request is `irq_valid` high for exactly one cycle, with `irq_vector` equal to entry bits 7:0.
- R9: An initial count of 0 stops the timer. The current count stays 0 and no request is made.
- R10: Writes to the current count register are ignored.
- R11: The entry word (address 0) stores bits 17, 16 and 7:0. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 entry, 1 initial, 2 current, 3 divide |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The assertions assume that a register write lasts one cycle and that a restart of the count is the only thing that resets the divider phase. They also assume that the divide setting may change at any time, so the tick-spacing check is relaxed in any cycle where the exponent changes. The stimulus writes each register in a single strobed cycle between clock edges. It programs the divide code and the entry word before loading the count, and it keeps counts small, so every expiry, including the one at a divide of 128, falls well inside the run.

// File: rtl/lapic_timer_pkg.sv
// Package: register selects, field positions and widths shared by the timer.
// Assumes a 32-bit register port with a 2-bit word address.
package lapic_timer_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int VEC_W   = 8;
    localparam int EXP_W   = 3;
    localparam int DIV_W   = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ENTRY   = 2'd0,
        SEL_INITIAL = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_DIVIDE  = 2'd3
    } reg_sel_e;

    localparam int BIT_PERIODIC = 17;
    localparam int BIT_MASK     = 16;
    localparam logic [DIV_W-1:0] DIV_KEEP = 4'b1011;
endpackage

// File: rtl/lapic_timer_regs.sv
// Register file: entry word, initial count, divide setting and read mux.
// Assumes the current count comes live from the counter; writes to it are dropped.
module lapic_timer_regs
    import lapic_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur_count,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] init_count,
    output logic              load,
    output logic              periodic,
    output logic              masked,
    output logic [VEC_W-1:0]  vector,
    output logic [EXP_W-1:0]  div_exp
);
    logic [DIV_W-1:0] div_q;
    logic             per_q;
    logic             msk_q;
    logic [VEC_W-1:0] vec_q;
    logic [EXP_W-1:0] code;

    // Register writes; the entry word comes out of reset with only the mask bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q      <= '0;
            per_q      <= 1'b0;
            msk_q      <= 1'b1;
            vec_q      <= '0;
            init_count <= '0;
        end else if (wr) begin
            case (reg_sel_e'(addr))
                SEL_ENTRY: begin
                    per_q <= wdata[BIT_PERIODIC];
                    msk_q <= wdata[BIT_MASK];
                    vec_q <= wdata[VEC_W-1:0];
                end
                SEL_INITIAL: init_count <= wdata;
                SEL_DIVIDE:  div_q <= wdata[DIV_W-1:0] & DIV_KEEP;
                default: ;
            endcase
        end
    end

    // Exponent decode: bit 3 supplies the top bit, then add one modulo eight.
    always_comb begin
        code    = {div_q[3], div_q[1:0]};
        div_exp = code + 3'd1;
    end

    // Read mux and field outputs.
    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            SEL_ENTRY: begin
                rdata[BIT_PERIODIC] = per_q;
                rdata[BIT_MASK]     = msk_q;
                rdata[VEC_W-1:0]    = vec_q;
            end
            SEL_INITIAL: rdata = init_count;
            SEL_CURRENT: rdata = cur_count;
            SEL_DIVIDE:  rdata[DIV_W-1:0] = div_q;
            default:     rdata = '0;
        endcase
    end

    assign load     = wr && (reg_sel_e'(addr) == SEL_INITIAL);
    assign periodic = per_q;
    assign masked   = msk_q;
    assign vector   = vec_q;

    assert_divmask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_e'(addr) == SEL_DIVIDE) |-> ((rdata & ~{28'd0, DIV_KEEP}) == '0));
    assert_entry_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_e'(addr) == SEL_ENTRY) |-> (rdata[DATA_W-1:BIT_PERIODIC+1] == '0 &&
                                             rdata[BIT_MASK-1:VEC_W] == '0));
endmodule

// File: rtl/lapic_timer_prescale.sv
// Prescaler: free-running phase counter that emits a tick every 2^exp cycles.
// Assumes exp never exceeds 2^EXP_W - 1; the phase is cleared on a count restart.
module lapic_timer_prescale #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [EXP_W-1:0] div_exp,
    output logic             tick
);
    localparam int PH_W = (1 << EXP_W) - 1;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] sel;

    // Phase counter, cleared on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    // Tick when all phase bits below the exponent are ones.
    always_comb begin
        sel  = PH_W'((1 << div_exp) - 1);
        tick = ((phase & sel) == sel);
    end

    assert_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && div_exp != '0) |=> (!tick || $past(div_exp) != div_exp));
endmodule

// File: rtl/lapic_timer_counter.sv
// Down-counter: loads, decrements per tick, reloads or stops on expiry, and
// registers the masked request. Assumes load has priority over a tick.
module lapic_timer_counter #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_count,
    input  logic             tick,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] count,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    logic armed;
    logic expire;

    // Expiry occurs on the tick after the count has reached zero.
    assign expire = !load && tick && armed && (count == '0);

    // Count state: load, decrement, reload in periodic mode, stop in one-shot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            armed <= 1'b0;
        end else if (load) begin
            count <= load_val;
            armed <= (load_val != '0);
        end else if (tick && armed) begin
            if (count != '0)   count <= count - 1'b1;
            else if (periodic) count <= init_count;
            else               armed <= 1'b0;
        end
    end

    // Request register: one-cycle pulse with the vector, unless masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid  <= expire && !masked;
            irq_vector <= expire ? vector : irq_vector;
        end
    end

    assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);
    assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && !$past(masked) == 1'b0) |=> !irq_valid);
    assert_zero_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !load) |=> (count == $past(count) && !irq_valid));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && count == '0 && !load) |=> (count == '0));
endmodule

// File: rtl/lapic_timer.sv
// Top: local interrupt controller countdown timer with a four-register port.
// Assumes single-cycle writes and a combinational read of the addressed register.
module lapic_timer
    import lapic_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    logic [DATA_W-1:0] cur_count;
    logic [DATA_W-1:0] init_count;
    logic              load;
    logic              periodic;
    logic              masked;
    logic [VEC_W-1:0]  vector;
    logic [EXP_W-1:0]  div_exp;
    logic              tick;

    lapic_timer_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cur_count(cur_count), .rdata(reg_rdata), .init_count(init_count),
        .load(load), .periodic(periodic), .masked(masked), .vector(vector),
        .div_exp(div_exp)
    );

    lapic_timer_prescale #(.EXP_W(EXP_W)) u_prescale (
        .clk(clk), .rst_n(rst_n), .restart(load), .div_exp(div_exp), .tick(tick)
    );

    lapic_timer_counter #(.CNT_W(DATA_W), .VEC_W(VEC_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(reg_wdata),
        .init_count(init_count), .tick(tick), .periodic(periodic), .masked(masked),
        .vector(vector), .count(cur_count), .irq_valid(irq_valid),
        .irq_vector(irq_vector)
    );
endmodule

// File: tb/test_lapic_timer.sv
module test_lapic_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // Stimulus table: {divide code[23:20], count[19:8], vector[7:0]}.
    localparam logic [23:0] VECS [8] = '{
        {4'hB, 12'd5, 8'h41}, {4'h0, 12'd3, 8'h52}, {4'h1, 12'd2, 8'h63},
        {4'h2, 12'd1, 8'h74}, {4'h3, 12'd2, 8'h85}, {4'h8, 12'd1, 8'h96},
        {4'h9, 12'd1, 8'hA7}, {4'hA, 12'd1, 8'hB8}
    };

    lapic_timer i_lapic_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
        .irq_vector(irq_vector)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    // Cycles after the current point until irq_valid is seen, up to lim.
    task automatic wait_irq(input int lim, output int k);
        k = 0;
        while (k < lim) begin
            @(posedge clk); #1; k++;
            if (irq_valid) return;
        end
        k = -1;
    endtask

    function automatic int exp_of(input logic [3:0] c);
        logic [2:0] e;
        e = {c[3], c[1:0]} + 3'd1;
        return int'(e);
    endfunction

    initial begin
        logic [31:0] v;
        int k;
        int per;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, v); check("R1 entry", v, 32'h0001_0000);
        rd(2'd1, v); check("R1 initial", v, 0);
        rd(2'd2, v); check("R1 current", v, 0);
        rd(2'd3, v); check("R1 divide", v, 0);
        check("R1 irq", {31'd0, irq_valid}, 0);

        // Table walk: one-shot expiry timing, vector, pulse width, hold at zero
        for (int i = 0; i < 8; i++) begin
            logic [3:0] c;
            logic [11:0] n;
            logic [7:0] vc;
            {c, n, vc} = VECS[i];
            wr(2'd3, {28'd0, c});
            wr(2'd0, {24'd0, vc});
            wr(2'd1, {20'd0, n});
            per = (int'(n) + 1) << exp_of(c);
            wait_irq(per + 4, k);
            check("R3 R5 expiry cycle", k, per);
            check("R8 vector", {24'd0, irq_vector}, {24'd0, vc});
            @(posedge clk); #1;
            check("R8 one-cycle pulse", {31'd0, irq_valid}, 0);
            wait_irq(2 * per, k);
            check("R5 single expiry", k, -1);
            rd(2'd2, v); check("R5 holds zero", v, 0);
        end

        // R2 divide bits, R11 entry bits
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); check("R2 divide keep", v, 32'h0000_000B);
        wr(2'd3, 32'hFFFF_FFF4); rd(2'd3, v); check("R2 divide drop", v, 0);
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R11 entry keep", v, 32'h0003_00FF);

        // R4 load and read back, R10 current-count write ignored
        wr(2'd3, 32'h0000_000B);
        wr(2'd0, 32'h0001_0033);
        wr(2'd1, 32'd100);
        rd(2'd2, v); check("R4 current loaded", v, 100);
        rd(2'd1, v); check("R4 initial readback", v, 100);
        wr(2'd2, 32'h0000_DEAD);
        rd(2'd2, v); check("R10 write ignored", v, 99);
        wr(2'd1, 32'd7);
        rd(2'd2, v); check("R4 restart", v, 7);

        // R7 masked periodic: no request, counting continues
        wr(2'd0, 32'h0003_0033);
        wr(2'd1, 32'd3);
        wait_irq(30, k);
        check("R7 masked no request", k, -1);
        rd(2'd2, v); check("R7 still counting", {31'd0, v <= 3}, 1);

        // R6 periodic spacing, N=3 divide by 1
        wr(2'd0, 32'h0002_0055);
        wr(2'd1, 32'd3);
        wait_irq(20, k); check("R6 first period", k, 4);
        check("R8 periodic vector", {24'd0, irq_vector}, 32'h55);
        wait_irq(20, k); check("R6 second period", k, 4);
        wait_irq(20, k); check("R6 third period", k, 4);

        // R6 periodic with divide by 4 (code 0x1), N=2
        wr(2'd3, 32'h0000_0001);
        wr(2'd1, 32'd2);
        wait_irq(40, k); check("R6 R3 divided period", k, 12);
        wait_irq(40, k); check("R6 R3 divided repeat", k, 12);

        // R9 zero count stops the timer
        wr(2'd1, 32'd0);
        wait_irq(60, k); check("R9 no request", k, -1);
        rd(2'd2, v); check("R9 count zero", v, 0);

        // R1 reset again mid-run
        wr(2'd1, 32'd50);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        rd(2'd2, v); check("R1 reset clears count", v, 0);
        rd(2'd0, v); check("R1 reset entry", v, 32'h0001_0000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule